// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a single column command into the per-beat column addresses of one SDRAM read or write burst, together with the timing strobes that go with each beat. A mode word, captured on a load pulse, chooses the burst length (1, 2, 4, 8 or a whole 512-column page), the wrap order, the read latency and whether writes burst or touch one location only.

A command pulse carries the direction, the starting column and the bank. From the next cycle on, the block presents one column address per cycle. For writes it raises a per-byte write enable in the same cycle, gated by the byte mask. For reads it raises a per-byte data-valid strobe a latency's worth of cycles after each beat, gated by the mask seen two cycles earlier. A new command, a burst-stop input or a precharge aimed at the burst's own bank cuts the burst short.

Top module: `sdram_burst_seq`

## Requirements
- R1: Length codes in mode bits [2:0] are 000=1, 001=2, 010=4, 011=8 beats (reserved codes 100..110 act as 1). A burst of length L presents exactly L consecutive beats, and `burst_done` is high only during the final one.
- R2: With mode bit 3 low (sequential), beat k carries `(base & ~(L-1)) | ((base + k) & (L-1))`, so the low bits count up and wrap inside the L-aligned block.
- R3: With mode bit 3 high (interleaved), beat k carries `(base & ~(L-1)) | ((base ^ k) & (L-1))`.
- R4: Length code 111 is a full page. It counts sequentially whatever bit 3 holds, wraps from column 511 to 0, never raises `burst_done`, and runs until it is stopped.
- R5: Latency field mode bits [6:4]: code 010 gives 2 and code 011 gives 3. The read strobe for the beat presented in cycle t appears in cycle t+latency. A write raises no read strobe.
- R6: Any other latency code raises `cl_err` until the next mode load, and reads then use latency 2.
- R7: With mode bit 9 high, a write presents a single beat with `burst_done`, while reads still run the full length.
- R8: During a write beat, `wr_en[i]` is high exactly when `mask_in[i]` is low in that same cycle. Outside write beats `wr_en` is zero.
- R9: A high `mask_in[i]` in cycle t clears `rd_valid[i]` in cycle t+2.
- R10: A command during a burst abandons it, and the new burst's beat 0 appears in the next cycle.
- R11: `term` high in a cycle with no command ends the burst, and there is no beat in the next cycle.
- R12: `pre` with `pre_bank` equal to the burst's bank ends the burst like R11. With a different bank it has no effect.
- R13: After reset all outputs are zero. Beat 0 appears in the cycle after the command, not in the command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture `mode_word` |
| mode_word | input | 10 | [2:0] length, [3] order, [6:4] latency, [9] single write |
| start | input | 1 | Column command pulse |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| start_col | input | COL_W | Starting column |
| cmd_bank | input | BANK_W | Bank of the command |
| term | input | 1 | Stop the current burst |
| pre | input | 1 | Precharge request |
| pre_bank | input | BANK_W | Bank of the precharge |
| mask_in | input | MASK_W | Per-byte mask |
| beat_valid | output | 1 | A beat is presented |
| col_addr | output | COL_W | Column of the current beat |
| burst_done | output | 1 | Final beat of a burst that ran its full length |
| wr_en | output | MASK_W | Per-byte write strobe |
| rd_valid | output | MASK_W | Per-byte read data valid |
| cl_err | output | 1 | Reserved latency code loaded |

## Verification
The assertions run on every cycle and cover the local rules. Beat 0 follows a command with the commanded column. The sequential count steps by one inside its block. No beat follows a stop or a completed burst. The read strobe stays clear two cycles after a mask. The error flag changes only on a mode load. The bench shows what needs whole scenarios: the address sequences against an arithmetic model over every length and both orders, the latency placement of read strobes, the page wrap, single-write mode, and how an interruption or a precharge to the same or another bank changes the rest of the burst.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int MODE_W = 10;
  localparam int MAX_CL = 3;

  localparam logic [2:0] BLC_2  = 3'b001;
  localparam logic [2:0] BLC_4  = 3'b010;
  localparam logic [2:0] BLC_8  = 3'b011;
  localparam logic [2:0] BLC_FP = 3'b111;
  localparam logic [2:0] CLC_2  = 3'b010;
  localparam logic [2:0] CLC_3  = 3'b011;

  typedef struct packed {
    logic [2:0] len_code;
    logic       ilv;
    logic       cl3;
    logic       cl_err;
    logic       single_wr;
  } mode_t;
endpackage

// File: rtl/sdram_mode_dec.sv
module sdram_mode_dec
  import sdram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (load) begin
      mode_d.len_code  = word[2:0];
      mode_d.ilv       = word[3];
      mode_d.cl3       = (word[6:4] == CLC_3);
      mode_d.cl_err    = (word[6:4] != CLC_2) && (word[6:4] != CLC_3);
      mode_d.single_wr = word[9];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              term,
  input  logic              pre,
  input  logic [BANK_W-1:0] pre_bank,
  input  mode_t             mode,
  output logic              beat_valid,
  output logic              beat_rd,
  output logic              last_beat,
  output logic [COL_W-1:0]  col_addr,
  output logic [COL_W-1:0]  blk_mask,
  output logic              blk_full,
  output logic              blk_ilv
);
  logic              act_q, act_d, rd_q, full_q, ilv_q;
  logic [COL_W-1:0]  base_q, idx_q, idx_d, mask_q, len_mask, step;
  logic [BANK_W-1:0] bank_q;
  logic              len_full, one_shot, stop;

  always_comb begin
    len_full = 1'b0;
    case (mode.len_code)
      BLC_2:   len_mask = COL_W'(1);
      BLC_4:   len_mask = COL_W'(3);
      BLC_8:   len_mask = COL_W'(7);
      BLC_FP:  begin len_mask = '1; len_full = 1'b1; end
      default: len_mask = '0;
    endcase
  end

  assign one_shot  = mode.single_wr & ~rd_nwr;
  assign stop      = term | (pre & (pre_bank == bank_q));
  assign last_beat = act_q & ~full_q & (idx_q == mask_q);

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (act_q) begin
      if (stop || last_beat) act_d = 1'b0;
      else                   idx_d = idx_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      bank_q <= '0;
      rd_q   <= 1'b0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start) begin
      base_q <= start_col;
      bank_q <= cmd_bank;
      rd_q   <= rd_nwr;
      mask_q <= one_shot ? '0 : len_mask;
      full_q <= len_full & ~one_shot;
      ilv_q  <= mode.ilv & ~len_full;
    end
  end

  assign step       = ilv_q ? (base_q ^ idx_q) : (base_q + idx_q);
  assign col_addr   = (base_q & ~mask_q) | (step & mask_q);
  assign beat_valid = act_q;
  assign beat_rd    = act_q & rd_q;
  assign blk_mask   = mask_q;
  assign blk_full   = full_q;
  assign blk_ilv    = ilv_q;
endmodule

// File: rtl/sdram_strobe_pipe.sv
module sdram_strobe_pipe
  import sdram_seq_pkg::*;
#(
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_rd,
  input  logic              beat_wr,
  input  logic              cl3,
  input  logic [MASK_W-1:0] mask_in,
  output logic [MASK_W-1:0] rd_valid,
  output logic [MASK_W-1:0] wr_en
);
  localparam int RD_MASK_LAG = 2;

  logic [MAX_CL-1:0]      rd_sh;
  logic [MASK_W-1:0]      mk_sh [RD_MASK_LAG];
  logic                   rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh    <= '0;
      mk_sh[0] <= '0;
      mk_sh[1] <= '0;
    end else begin
      rd_sh    <= {rd_sh[MAX_CL-2:0], beat_rd};
      mk_sh[0] <= mask_in;
      mk_sh[1] <= mk_sh[0];
    end
  end

  assign rd_sel = cl3 ? rd_sh[MAX_CL-1] : rd_sh[MAX_CL-2];

  for (genvar g = 0; g < MASK_W; g++) begin : g_lane
    assign rd_valid[g] = rd_sel & ~mk_sh[RD_MASK_LAG-1][g];
    assign wr_en[g]    = beat_wr & ~mask_in[g];
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              term,
  input  logic              pre,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic [MASK_W-1:0] mask_in,
  output logic              beat_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              burst_done,
  output logic [MASK_W-1:0] wr_en,
  output logic [MASK_W-1:0] rd_valid,
  output logic              cl_err
);
  logic [1:0]       rst_sh;
  logic             rst_s;
  mode_t            mode;
  logic             beat_rd, last_beat, blk_full, blk_ilv;
  logic [COL_W-1:0] blk_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_s = rst_sh[1];

  sdram_mode_dec u_mode (
    .clk  (clk),
    .rst_n(rst_s),
    .load (mode_load),
    .word (mode_word),
    .mode (mode)
  );

  sdram_col_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_s),
    .start     (start),
    .rd_nwr    (rd_nwr),
    .start_col (start_col),
    .cmd_bank  (cmd_bank),
    .term      (term),
    .pre       (pre),
    .pre_bank  (pre_bank),
    .mode      (mode),
    .beat_valid(beat_valid),
    .beat_rd   (beat_rd),
    .last_beat (last_beat),
    .col_addr  (col_addr),
    .blk_mask  (blk_mask),
    .blk_full  (blk_full),
    .blk_ilv   (blk_ilv)
  );

  sdram_strobe_pipe #(.MASK_W(MASK_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_s),
    .beat_rd (beat_rd),
    .beat_wr (beat_valid & ~beat_rd),
    .cl3     (mode.cl3),
    .mask_in (mask_in),
    .rd_valid(rd_valid),
    .wr_en   (wr_en)
  );

  assign burst_done = last_beat;
  assign cl_err     = mode.cl_err;
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int COL_W  = 9,
  parameter int MASK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              term,
  input logic [COL_W-1:0]  start_col,
  input logic              mode_load,
  input logic [MASK_W-1:0] mask_in,
  input logic              beat_valid,
  input logic [COL_W-1:0]  col_addr,
  input logic [MASK_W-1:0] rd_valid,
  input logic              burst_done,
  input logic              cl_err,
  input logic [COL_W-1:0]  blk_mask,
  input logic              blk_ilv
);
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (beat_valid && col_addr == $past(start_col))); // R13

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(start) && !blk_ilv)
      |-> ((col_addr & blk_mask) == (($past(col_addr) + COL_W'(1)) & blk_mask))); // R2

  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(start))
      |-> ((col_addr & ~blk_mask) == ($past(col_addr) & ~blk_mask))); // R3

  AST_STOP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(term) && !$past(start)) |-> !beat_valid); // R11

  AST_END_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(burst_done) && !$past(start)) |-> !beat_valid); // R1

  AST_RD_MASK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid & $past(mask_in, 2)) == '0); // R9

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_load) |-> $stable(cl_err)); // R6
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W), .MASK_W(MASK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .term      (term),
  .start_col (start_col),
  .mode_load (mode_load),
  .mask_in   (mask_in),
  .beat_valid(beat_valid),
  .col_addr  (col_addr),
  .rd_valid  (rd_valid),
  .burst_done(burst_done),
  .cl_err    (cl_err),
  .blk_mask  (blk_mask),
  .blk_ilv   (blk_ilv)
);

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 9;
  localparam int BANK_W = 2;
  localparam int MASK_W = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mode_load;
  logic [9:0]        mode_word;
  logic              start, rd_nwr, term, pre;
  logic [COL_W-1:0]  start_col;
  logic [BANK_W-1:0] cmd_bank, pre_bank;
  logic [MASK_W-1:0] mask_in;
  logic              beat_valid, burst_done, cl_err;
  logic [COL_W-1:0]  col_addr;
  logic [MASK_W-1:0] wr_en, rd_valid;

  int checks = 0;
  int errors = 0;
  int blen, col, cl;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W), .BANK_W(BANK_W), .MASK_W(MASK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .rd_nwr(rd_nwr), .start_col(start_col), .cmd_bank(cmd_bank),
    .term(term), .pre(pre), .pre_bank(pre_bank), .mask_in(mask_in),
    .beat_valid(beat_valid), .col_addr(col_addr), .burst_done(burst_done),
    .wr_en(wr_en), .rd_valid(rd_valid), .cl_err(cl_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_mode(input logic [2:0] lc, input logic o, input logic [2:0] clc,
                           input logic single);
    mode_word = {single, 2'b00, clc, o, lc};
    mode_load = 1'b1;
    tick();
    mode_load = 1'b0;
  endtask

  task automatic cmd(input logic rd, input int c, input logic [BANK_W-1:0] b);
    start = 1'b1; rd_nwr = rd; start_col = COL_W'(c); cmd_bank = b;
    tick();
    start = 1'b0;
  endtask

  function automatic int expc(input int base, input int k, input int len, input bit o);
    int blk = (base / len) * len;
    int off = base % len;
    return o ? blk + (off ^ k) : blk + ((off + k) % len);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_word = '0; start = 1'b0; rd_nwr = 1'b0;
    term = 1'b0; pre = 1'b0; start_col = '0; cmd_bank = '0; pre_bank = '0; mask_in = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R13: reset state and first-beat timing
    chk("R13 reset beat_valid", beat_valid, 0);
    chk("R13 reset burst_done", burst_done, 0);
    chk("R13 reset wr_en", wr_en, 0);
    chk("R13 reset rd_valid", rd_valid, 0);
    chk("R13 reset cl_err", cl_err, 0);
    start = 1'b1; rd_nwr = 1'b0; start_col = 9'd5; cmd_bank = 2'd0;
    #1 chk("R13 no beat in command cycle", beat_valid, 0);
    tick(); start = 1'b0;
    chk("R13 beat 0 next cycle", beat_valid, 1);
    chk("R13 beat 0 column", col_addr, 5);
    tick();

    // R1 R2 R3 R8: every length, both orders, swept start columns
    for (int lc = 0; lc < 4; lc++) begin
      for (int o = 0; o < 2; o++) begin
        load_mode(3'(lc), o[0], 3'b010, 1'b0);
        blen = 1 << lc;
        for (int c = 0; c < 28; c++) begin
          col = (c < 16) ? c : 484 + c;
          cmd(c[0], col, 2'd0);
          for (int k = 0; k < blen; k++) begin
            chk(o ? "R3 interleaved column" : "R2 sequential column", col_addr,
                expc(col, k, blen, o[0]));
            chk("R1 beat present", beat_valid, 1);
            chk("R1 done on last beat only", burst_done, (k == blen - 1) ? 1 : 0);
            chk("R8 write strobe unmasked", wr_en, c[0] ? 0 : 3);
            tick();
          end
          chk("R1 no beat after length", beat_valid, 0);
        end
      end
    end
    repeat (4) tick();

    // R5 R6: read latency placement and reserved latency code
    for (int t = 0; t < 3; t++) begin
      load_mode(3'b010, 1'b0, (t == 0) ? 3'b010 : (t == 1) ? 3'b011 : 3'b101, 1'b0);
      cl = (t == 1) ? 3 : 2;
      chk("R6 error flag", cl_err, (t == 2) ? 1 : 0);
      repeat (4) tick();
      cmd(1'b1, 8, 2'd0);
      for (int n = 0; n < 4 + cl + 2; n++) begin
        chk((t == 2) ? "R6 reserved code uses latency 2" : "R5 read strobe at latency",
            rd_valid, (n >= cl && n < cl + 4) ? 3 : 0);
        chk("R5 no write strobe on read", wr_en, 0);
        tick();
      end
    end

    // R9: read mask takes effect two cycles later
    load_mode(3'b010, 1'b0, 3'b010, 1'b0);
    repeat (4) tick();
    cmd(1'b1, 0, 2'd0);
    for (int n = 0; n < 7; n++) begin
      chk("R9 read mask lag", rd_valid,
          (n == 3) ? 2 : (n >= 2 && n <= 5) ? 3 : 0);
      mask_in = (n == 1) ? 2'b01 : 2'b00;
      tick();
    end
    mask_in = '0;

    // R8: write mask in the same cycle
    cmd(1'b0, 0, 2'd0);
    tick();
    mask_in = 2'b10;
    #1 chk("R8 write mask same cycle", wr_en, 1);
    tick();
    mask_in = 2'b00;
    #1 chk("R8 write unmasked beat", wr_en, 3);
    repeat (3) tick();
    chk("R8 no strobe when idle", wr_en, 0);

    // R7: single-location writes, reads still burst
    load_mode(3'b011, 1'b0, 3'b010, 1'b1);
    cmd(1'b0, 16, 2'd0);
    chk("R7 single write beat", beat_valid, 1);
    chk("R7 single write done", burst_done, 1);
    tick();
    chk("R7 single write ends", beat_valid, 0);
    cmd(1'b1, 16, 2'd0);
    for (int k = 0; k < 8; k++) begin
      chk("R7 read still bursts", beat_valid, 1);
      tick();
    end
    chk("R7 read burst ends", beat_valid, 0);

    // R4 R11: full page wraps, no done, stopped by term
    load_mode(3'b111, 1'b1, 3'b010, 1'b0);
    cmd(1'b0, 508, 2'd0);
    for (int k = 0; k < 10; k++) begin
      chk("R4 full page column", col_addr, (508 + k) % 512);
      chk("R4 full page no done", burst_done, 0);
      if (k == 9) term = 1'b1;
      tick();
    end
    term = 1'b0;
    chk("R11 term ends burst", beat_valid, 0);

    // R12: precharge to other bank ignored, same bank stops
    load_mode(3'b011, 1'b0, 3'b010, 1'b0);
    cmd(1'b1, 0, 2'd1);
    for (int k = 0; k < 8; k++) begin
      chk("R12 other-bank precharge ignored", col_addr, k);
      chk("R12 other-bank beat kept", beat_valid, 1);
      pre = (k == 2); pre_bank = 2'd2;
      tick();
    end
    pre = 1'b0;
    chk("R12 burst completes", beat_valid, 0);
    cmd(1'b1, 0, 2'd1);
    tick(); tick();
    pre = 1'b1; pre_bank = 2'd1;
    tick();
    pre = 1'b0;
    chk("R12 same-bank precharge stops", beat_valid, 0);

    // R10: new command interrupts a burst
    cmd(1'b0, 32, 2'd0);
    for (int k = 0; k < 4; k++) begin
      chk("R10 first burst column", col_addr, 32 + k);
      if (k < 3) tick();
    end
    cmd(1'b1, 100, 2'd0);
    for (int k = 0; k < 8; k++) begin
      chk("R10 new burst column", col_addr, expc(100, k, 8, 1'b0));
      chk("R10 new burst done", burst_done, (k == 7) ? 1 : 0);
      tick();
    end
    chk("R10 new burst ends", beat_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule